// File: doc/BRIEF.md
# Display Window Update Sequencer

This block refreshes a rectangular region of a panel's frame memory over a byte-wide command bus. A request carries a start corner (`req_x1`, `req_y1`, inclusive) and an end corner (`req_x2`, `req_y2`, exclusive). The block then emits a byte stream. Each byte is tagged as a command or as data, and each is handed over on a valid/ready handshake. The stream first sets the column range, then the row range, and then opens a frame-memory write. It follows that with the window's RGB565 pixels, which it takes from a pixel valid/ready input and sends high byte first.

After reset the block drives the panel reset line low, releases it, and waits out a settling time before it accepts any work. It can also blank the whole panel on request by writing a full-screen window filled with zero pixels. The surrounding logic gates refresh requests with `enable`. A request accepted while `enable` is low is dropped without any output.

Top module: `disp_win_seq`

## Requirements
- R1: Internal reset is released two clock edges after `rst_n` rises. `lcd_rst_n` then stays low for LOW_CYC = CLK_HZ/1000*RST_LOW_MS more edges, so it rises LOW_CYC+2 edges after release. `req_ready` rises exactly WAIT_CYC = CLK_HZ/1000*RST_WAIT_MS edges after `lcd_rst_n` rises.
- R2: `out_valid` and `done` stay low from reset until the panel reset sequence has finished.
- R3: A refresh starts with command byte 0x2A (`out_dc`=0), followed by four data bytes (`out_dc`=1): x1 high byte, x1 low byte, (x2-1) high byte and (x2-1) low byte, each taken modulo 2^16.
- R4: Command byte 0x2B (`out_dc`=0) comes next, followed by y1 high, y1 low, (y2-1) high and (y2-1) low as data bytes.
- R5: Command byte 0x2C (`out_dc`=0) comes next, followed by max(x2-x1,0)*max(y2-y1,0) pixels. Each pixel is two data bytes, bits 15:8 first, then bits 7:0. An empty window sends no pixel bytes.
- R6: One input pixel is consumed for each pixel sent, and consumption happens when its low byte is accepted. The pixels go out in the order they were received.
- R7: While a command or parameter byte is offered and not accepted, `out_valid`, `out_byte` and `out_dc` hold steady.
- R8: `done` is high for exactly one cycle, the cycle after the last byte of a sequence is accepted. The block is idle again in the cycle after that.
- R9: A request accepted while `enable` is low produces no output bytes and no `done`.
- R10: A `blank_req` in idle sets the column range to 0..PANEL_W-1 and the row range to 0..PANEL_H-1. It then sends PANEL_W*PANEL_H zero pixels and never asserts `pix_ready`. If `blank_req` and `req_valid` arrive in the same cycle, blank wins and `req_ready` is low.
- R11: `req_ready` is high only when the block is idle after the reset sequence, and never while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Refresh requests take effect only while high |
| req_valid | input | 1 | Window request present |
| req_ready | output | 1 | Window request taken this cycle |
| req_x1 | input | COORD_W | First column, inclusive |
| req_y1 | input | COORD_W | First row, inclusive |
| req_x2 | input | COORD_W | Column bound, exclusive |
| req_y2 | input | COORD_W | Row bound, exclusive |
| blank_req | input | 1 | Start a full-screen zero fill (sampled in idle) |
| pix_valid | input | 1 | Pixel word present |
| pix_ready | output | 1 | Pixel word consumed this cycle |
| pix_data | input | 16 | RGB565 pixel |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Output byte accepted this cycle |
| out_byte | output | 8 | Output byte |
| out_dc | output | 1 | 0 = command byte, 1 = parameter or pixel byte |
| lcd_rst_n | output | 1 | Panel reset line, active low |
| done | output | 1 | One-cycle pulse after the last byte of a sequence |

## Verification
The bytes on the output are combinational in the current state, so a byte is due in the cycle it is offered. The bench samples `out_valid`, `out_ready` and `pix_ready` one time unit after each falling edge and logs a transfer that completes on the next rising edge. The `done` pulse is due one edge after the last transfer. The bench therefore requires `done` at the sample that follows the last logged byte, and idle with `req_ready` high at the sample after that. For the reset timing the bench counts rising edges from reset release: LOW_CYC+2 until `lcd_rst_n` rises, then WAIT_CYC until `req_ready` rises.

// File: rtl/dws_pkg.sv
package dws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PIX  = 2'd2,
    ST_DONE = 2'd3
  } dws_state_e;

  localparam logic [7:0] DWS_CMD_COLS  = 8'h2A;
  localparam logic [7:0] DWS_CMD_ROWS  = 8'h2B;
  localparam logic [7:0] DWS_CMD_MEMWR = 8'h2C;
  localparam int         DWS_STEP_W    = 4;
  localparam int         DWS_HDR_LAST  = 10;
  localparam int         DWS_SYNC_LEN  = 2;
endpackage

// File: rtl/dws_rst_timer.sv
module dws_rst_timer #(
  parameter int LOW_CYC  = 1000,
  parameter int WAIT_CYC = 6000
) (
  input  logic clk,
  input  logic rst_n,
  output logic lcd_rst_n,
  output logic rst_ok
);
  localparam int MAX_CYC = (LOW_CYC > WAIT_CYC) ? LOW_CYC : WAIT_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic          low_q, low_d;
  logic          ok_q, ok_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    low_d = low_q;
    ok_d  = ok_q;
    cnt_d = cnt_q;
    if (low_q) begin
      if (cnt_q == CW'(LOW_CYC - 1)) begin
        low_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (!ok_q) begin
      if (cnt_q == CW'(WAIT_CYC - 1)) ok_d = 1'b1;
      else                            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b1;
      ok_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      low_q <= low_d;
      ok_q  <= ok_d;
      cnt_q <= cnt_d;
    end
  end

  assign lcd_rst_n = ~low_q;
  assign rst_ok    = ok_q;

  // R1: once released, the panel reset line never drops again
  a_r1_line_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_rst_n |=> lcd_rst_n);
  // R1: readiness only after the line has been released
  a_r1_ok_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ok |-> lcd_rst_n);
endmodule

// File: rtl/dws_hdr_byte.sv
module dws_hdr_byte
  import dws_pkg::*;
(
  input  logic [DWS_STEP_W-1:0] step,
  input  logic [15:0]           col_s,
  input  logic [15:0]           col_e,
  input  logic [15:0]           row_s,
  input  logic [15:0]           row_e,
  output logic [7:0]            hb,
  output logic                  dc
);
  always_comb begin
    dc = 1'b1;
    hb = 8'h00;
    case (step)
      4'd0:  begin hb = DWS_CMD_COLS;  dc = 1'b0; end
      4'd1:  hb = col_s[15:8];
      4'd2:  hb = col_s[7:0];
      4'd3:  hb = col_e[15:8];
      4'd4:  hb = col_e[7:0];
      4'd5:  begin hb = DWS_CMD_ROWS;  dc = 1'b0; end
      4'd6:  hb = row_s[15:8];
      4'd7:  hb = row_s[7:0];
      4'd8:  hb = row_e[15:8];
      4'd9:  hb = row_e[7:0];
      4'd10: begin hb = DWS_CMD_MEMWR; dc = 1'b0; end
      default: begin hb = 8'h00; dc = 1'b0; end
    endcase
  end
endmodule

// File: rtl/dws_pix_cnt.sv
module dws_pix_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             is_zero,
  output logic             is_last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign is_zero = (cnt_q == '0);
  assign is_last = (cnt_q == CNT_W'(1));

  // R5: a pixel is never sent beyond the window's count
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !is_zero);
endmodule

// File: rtl/disp_win_seq.sv
module disp_win_seq
  import dws_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int RST_LOW_MS  = 20,
  parameter int RST_WAIT_MS = 120,
  parameter int COORD_W     = 16,
  parameter int PANEL_W     = 240,
  parameter int PANEL_H     = 320
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [COORD_W-1:0] req_x1,
  input  logic [COORD_W-1:0] req_y1,
  input  logic [COORD_W-1:0] req_x2,
  input  logic [COORD_W-1:0] req_y2,
  input  logic               blank_req,
  input  logic               pix_valid,
  output logic               pix_ready,
  input  logic [15:0]        pix_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_byte,
  output logic               out_dc,
  output logic               lcd_rst_n,
  output logic               done
);
  localparam int LOW_CYC  = CLK_HZ / 1000 * RST_LOW_MS;
  localparam int WAIT_CYC = CLK_HZ / 1000 * RST_WAIT_MS;
  localparam int CNT_W    = 2 * COORD_W;
  localparam logic [CNT_W-1:0] BLANK_PIX = CNT_W'(PANEL_W * PANEL_H);

  // reset: asynchronous assert, synchronous release
  logic [DWS_SYNC_LEN-1:0] sync_q;
  logic                    rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[DWS_SYNC_LEN-2:0], 1'b1};
  end
  assign rst_i = sync_q[DWS_SYNC_LEN-1];

  logic rst_ok;
  dws_rst_timer #(.LOW_CYC(LOW_CYC), .WAIT_CYC(WAIT_CYC)) u_rst_timer (
    .clk(clk), .rst_n(rst_i), .lcd_rst_n(lcd_rst_n), .rst_ok(rst_ok)
  );

  dws_state_e            state_q, state_d;
  logic [DWS_STEP_W-1:0] step_q, step_d;
  logic                  lo_q, lo_d;
  logic                  blank_q;
  logic [15:0]           col_s_q, col_e_q, row_s_q, row_e_q;

  logic idle, take_blank, take_req, start, xfer, dec, cnt_zero, cnt_last;
  logic [7:0] hdr_b;
  logic       hdr_dc;
  logic [COORD_W-1:0] span_x, span_y;
  logic [CNT_W-1:0]   area, load_val;

  assign idle       = rst_ok && (state_q == ST_IDLE);
  assign req_ready  = idle && !blank_req;
  assign take_blank = idle && blank_req;
  assign take_req   = req_valid && req_ready && enable;
  assign start      = take_blank || take_req;

  assign span_x   = (req_x2 > req_x1) ? (req_x2 - req_x1) : '0;
  assign span_y   = (req_y2 > req_y1) ? (req_y2 - req_y1) : '0;
  assign area     = CNT_W'(span_x) * CNT_W'(span_y);
  assign load_val = take_blank ? BLANK_PIX : area;

  dws_hdr_byte u_hdr (
    .step(step_q), .col_s(col_s_q), .col_e(col_e_q),
    .row_s(row_s_q), .row_e(row_e_q), .hb(hdr_b), .dc(hdr_dc)
  );

  dws_pix_cnt #(.CNT_W(CNT_W)) u_pix_cnt (
    .clk(clk), .rst_n(rst_i), .load(start), .load_val(load_val),
    .dec(dec), .is_zero(cnt_zero), .is_last(cnt_last)
  );

  // output byte selection
  always_comb begin
    out_valid = 1'b0;
    out_byte  = 8'h00;
    out_dc    = 1'b0;
    case (state_q)
      ST_HDR: begin
        out_valid = 1'b1;
        out_byte  = hdr_b;
        out_dc    = hdr_dc;
      end
      ST_PIX: begin
        out_valid = blank_q || pix_valid;
        out_dc    = 1'b1;
        if (!blank_q) out_byte = lo_q ? pix_data[7:0] : pix_data[15:8];
      end
      default: ;
    endcase
  end

  assign xfer      = out_valid && out_ready;
  assign pix_ready = (state_q == ST_PIX) && !blank_q && lo_q && out_ready;
  assign dec       = (state_q == ST_PIX) && xfer && lo_q;
  assign done      = (state_q == ST_DONE);

  // next state
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    lo_d    = lo_q;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_HDR;
        step_d  = '0;
        lo_d    = 1'b0;
      end
      ST_HDR: if (xfer) begin
        if (step_q == DWS_STEP_W'(DWS_HDR_LAST)) state_d = cnt_zero ? ST_DONE : ST_PIX;
        else                                     step_d  = step_q + 1'b1;
      end
      ST_PIX: if (xfer) begin
        lo_d = ~lo_q;
        if (lo_q && cnt_last) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      lo_q    <= 1'b0;
      blank_q <= 1'b0;
      col_s_q <= '0;
      col_e_q <= '0;
      row_s_q <= '0;
      row_e_q <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      lo_q    <= lo_d;
      if (start) begin
        blank_q <= take_blank;
        col_s_q <= take_blank ? 16'd0 : 16'(req_x1);
        col_e_q <= take_blank ? 16'(PANEL_W - 1) : 16'(req_x2) - 16'd1;
        row_s_q <= take_blank ? 16'd0 : 16'(req_y1);
        row_e_q <= take_blank ? 16'(PANEL_H - 1) : 16'(req_y2) - 16'd1;
      end
    end
  end

  // R2: nothing is sent while the panel is held in reset
  a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_i)
    !lcd_rst_n |-> !out_valid);
  // R7: an offered header byte holds until taken
  a_r7_hdr_hold: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_HDR && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_dc)));
  // R6: a high pixel byte is always followed by its low byte
  a_r6_hi_then_lo: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_PIX && xfer && !lo_q) |=> (state_q == ST_PIX && lo_q));
  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !done);
  // R10: a blank fill never pulls pixels
  a_r10_blank_no_pull: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_PIX && blank_q) |-> !pix_ready);
  // R11: no request accepted while bytes are flowing
  a_r11_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_i)
    req_ready |-> !out_valid);
endmodule

// File: tb/disp_win_seq_tb.sv
module disp_win_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 10_000;
  localparam int LOW_CYC    = CLK_HZ / 1000 * 20;
  localparam int WAIT_CYC   = CLK_HZ / 1000 * 120;
  localparam int PW         = 6;
  localparam int PH         = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rst_n, enable, req_valid, req_ready, blank_req;
  logic [15:0] req_x1, req_y1, req_x2, req_y2;
  logic        pix_valid, pix_ready, out_valid, out_ready, out_dc, lcd_rst_n, done;
  logic [15:0] pix_data;
  logic [7:0]  out_byte;

  disp_win_seq #(.CLK_HZ(CLK_HZ), .COORD_W(16), .PANEL_W(PW), .PANEL_H(PH)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .req_valid(req_valid), .req_ready(req_ready),
    .req_x1(req_x1), .req_y1(req_y1), .req_x2(req_x2), .req_y2(req_y2),
    .blank_req(blank_req), .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte), .out_dc(out_dc),
    .lcd_rst_n(lcd_rst_n), .done(done)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pix_fn(input int k);
    return 16'((k * 13627 + 5) ^ (k << 9));
  endfunction

  // mode 0: refresh request, 1: blank, 2: blank and request together
  task automatic run_txn(input int mode, input logic [15:0] x1, input logic [15:0] y1,
                         input logic [15:0] x2, input logic [15:0] y2);
    logic [8:0]  exp_q[$];
    logic [8:0]  got_q[$];
    logic [15:0] cs, ce, rs, re, pv;
    int npix, pidx, last_x, done_c, busy_rdy, bad;
    bit is_blank;
    is_blank = (mode != 0);
    if (is_blank) begin
      cs = 0; ce = 16'(PW - 1); rs = 0; re = 16'(PH - 1); npix = PW * PH;
    end else begin
      cs = x1; ce = x2 - 16'd1; rs = y1; re = y2 - 16'd1;
      npix = ((x2 > x1) ? int'(x2 - x1) : 0) * ((y2 > y1) ? int'(y2 - y1) : 0);
    end
    exp_q.push_back({1'b0, 8'h2A});
    exp_q.push_back({1'b1, cs[15:8]}); exp_q.push_back({1'b1, cs[7:0]});
    exp_q.push_back({1'b1, ce[15:8]}); exp_q.push_back({1'b1, ce[7:0]});
    exp_q.push_back({1'b0, 8'h2B});
    exp_q.push_back({1'b1, rs[15:8]}); exp_q.push_back({1'b1, rs[7:0]});
    exp_q.push_back({1'b1, re[15:8]}); exp_q.push_back({1'b1, re[7:0]});
    exp_q.push_back({1'b0, 8'h2C});
    for (int k = 0; k < npix; k++) begin
      pv = is_blank ? 16'h0000 : pix_fn(k);
      exp_q.push_back({1'b1, pv[15:8]});
      exp_q.push_back({1'b1, pv[7:0]});
    end

    @(negedge clk);
    out_ready = 1'b0; pix_valid = 1'b0;
    req_x1 = x1; req_y1 = y1; req_x2 = x2; req_y2 = y2;
    req_valid = (mode != 1);
    blank_req = (mode != 0);
    #1;
    if (mode == 2) check(req_ready == 1'b0, "R10", "req_ready with blank pending", int'(req_ready), 0);
    if (mode == 0) check(req_ready == 1'b1, "R11", "req_ready in idle", int'(req_ready), 1);

    pidx = 0; last_x = -1; done_c = -1; busy_rdy = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cyc++;
      req_valid = 1'b0; blank_req = 1'b0;
      out_ready = (((cyc * 7 + 3) % 5) != 0);
      pix_valid = ((cyc % 3) != 1);
      pix_data  = pix_fn(pidx);
      #1;
      if (done) begin done_c = i; break; end
      if (req_ready) busy_rdy++;
      if (out_valid && out_ready) begin
        got_q.push_back({out_dc, out_byte});
        last_x = i;
      end
      if (pix_valid && pix_ready) pidx++;
    end
    check(done_c >= 0, "R8", "done seen before timeout", done_c, 0);

    check(got_q.size() == exp_q.size(), "R5", "byte count", got_q.size(), exp_q.size());
    bad = -1;
    for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
      if (bad < 0 && got_q[k] !== exp_q[k]) bad = k;
    if (bad < 0) check(1'b1, "R3", "stream", 0, 0);
    else if (bad < 5)  check(1'b0, "R3", "column byte {dc,byte}", int'(got_q[bad]), int'(exp_q[bad]));
    else if (bad < 10) check(1'b0, "R4", "row byte {dc,byte}", int'(got_q[bad]), int'(exp_q[bad]));
    else               check(1'b0, "R5", "write/pixel byte {dc,byte}", int'(got_q[bad]), int'(exp_q[bad]));
    if (is_blank) check(pidx == 0, "R10", "pixels pulled during blank", pidx, 0);
    else          check(pidx == npix, "R6", "pixels consumed", pidx, npix);
    check(done_c == last_x + 1, "R8", "done cycle after last byte", done_c, last_x + 1);
    check(busy_rdy == 0, "R11", "req_ready cycles while busy", busy_rdy, 0);
    @(negedge clk);
    cyc++;
    #1;
    check(done == 1'b0 && req_ready == 1'b1, "R8", "idle after done pulse",
          int'({done, req_ready}), 1);
  endtask

  int yp_s[3] = '{0, 1, 2};
  int yp_e[3] = '{2, 1, 5};

  initial begin
    int n, m, saw_v;
    rst_n = 1'b0; enable = 1'b1; req_valid = 1'b0; blank_req = 1'b0;
    req_x1 = 0; req_y1 = 0; req_x2 = 0; req_y2 = 0;
    pix_valid = 1'b0; pix_data = 0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(lcd_rst_n == 1'b0 && out_valid == 1'b0 && done == 1'b0 && req_ready == 1'b0,
          "R2", "reset state {lcd_rst_n,out_valid,done,req_ready}",
          int'({lcd_rst_n, out_valid, done, req_ready}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0; saw_v = 0;
    while (n < 20000) begin
      @(posedge clk); #1; n++;
      if (out_valid || done || req_ready) saw_v++;
      if (lcd_rst_n) break;
    end
    check(n == LOW_CYC + 2, "R1", "edges to panel reset release", n, LOW_CYC + 2);
    m = 0;
    while (m < 20000) begin
      @(posedge clk); #1; m++;
      if (req_ready) break;
      if (out_valid || done) saw_v++;
    end
    check(m == WAIT_CYC, "R1", "edges from release to ready", m, WAIT_CYC);
    check(saw_v == 0, "R2", "activity during reset sequence", saw_v, 0);

    // disabled: request is taken and dropped
    enable = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_x1 = 1; req_y1 = 1; req_x2 = 3; req_y2 = 3;
    #1;
    check(req_ready == 1'b1, "R9", "request taken while disabled", int'(req_ready), 1);
    saw_v = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); req_valid = 1'b0; out_ready = 1'b1; #1;
      if (out_valid || done) saw_v++;
    end
    check(saw_v == 0, "R9", "output cycles after disabled request", saw_v, 0);
    enable = 1'b1;

    // sweep of small windows, including empty and inverted ones
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 5; b++)
        for (int yp = 0; yp < 3; yp++)
          run_txn(0, 16'(a), 16'(yp_s[yp]), 16'(b), 16'(yp_e[yp]));

    // high-byte boundaries and end of address space
    run_txn(0, 16'd250, 16'd255, 16'd260, 16'd257);
    run_txn(0, 16'd0, 16'd0, 16'd0, 16'd1);
    run_txn(0, 16'hFFFE, 16'h00FF, 16'hFFFF, 16'h0101);

    // blank fill, alone and against a concurrent request
    run_txn(1, 16'd0, 16'd0, 16'd0, 16'd0);
    run_txn(2, 16'd1, 16'd1, 16'd4, 16'd3);
    run_txn(0, 16'd2, 16'd0, 16'd5, 16'd2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule